// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the serial clock for an I2C master. A prescaler first divides the system clock by (prescale + 1) to give a module tick. Two phase counters then time the low half and the high half of each SCL period in module ticks. Each half lasts its programmed count plus a fixed overhead. The overhead is 7 ticks when the prescale value is 0, 6 ticks when it is 1, and 5 ticks for any larger value. A build option fixes the overhead at 6 for every prescale value. The bit engine reads the SCL level on `scl_o` (1 = released, 0 = driven low). It also gets a one-cycle `phase_end` strobe on the last cycle of every phase.

The three 16-bit settings are captured only while the module enable is low, so new values take effect once the module is enabled again. While the module is disabled the block stays idle with SCL released. A transfer starts when `run` is high, the module is enabled and the captured high count is non-zero. A zero high count means no clock is produced. The high phase does not start counting until the synchronised SCL line reads high, so a target device can stretch the clock. When `run` drops, the block finishes the phase in progress and the high phase that follows it, then parks with SCL high.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, and while the module is disabled, `scl_o` is 1 and `phase_end` and `stretch_wait` are 0.
- R2: A low phase lasts exactly (low_count + d) × (prescale + 1) system clock cycles, where d is the overhead.
- R3: When the line follows `scl_o` with no stretching, a high phase lasts SYNC_STAGES + (high_count + d) × (prescale + 1) cycles.
- R4: d is 7 for prescale 0, 6 for prescale 1, and 5 for prescale 2 or more.
- R5: With FIXED_OVH = 1, d is 6 for every prescale value.
- R6: If the captured high count is 0, `scl_o` stays 1 even with `run` and the module enable both high.
- R7: One cycle after the module enable is seen low, `scl_o` is 1, whatever phase was active.
- R8: Settings presented while the module is enabled have no effect. The captured values change only while the enable is low.
- R9: While the synchronised line reads low during a high phase, `stretch_wait` is 1, the phase does not end, and `scl_o` stays 1. Counting starts once the line reads high, so the phase ends SYNC_STAGES + (high_count + d) × (prescale + 1) cycles after the line is released.
- R10: After `run` falls during a low phase, the block completes that low phase and one high phase, then stays idle with `scl_o` = 1 and no further `phase_end`.
- R11: `phase_end` is a single-cycle pulse on the last cycle of each phase, exactly once per phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Module enable; low holds the block idle and captures the settings |
| run | input | 1 | Request to generate SCL periods |
| psc_in | input | CNT_W | Prescale setting; module tick = clk / (psc_in + 1) |
| lo_in | input | CNT_W | Low-phase count in module ticks, before overhead |
| hi_in | input | CNT_W | High-phase count in module ticks, before overhead; 0 disables clocking |
| scl_in | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL phase: 1 released/high, 0 driven low |
| phase_end | output | 1 | Pulses on the last cycle of each phase |
| stretch_wait | output | 1 | High phase is waiting for the line to read high |

## Verification
The bench measures phase lengths at prescale 0, 1, 2 and 3. This catches a design that picks the wrong overhead at the 0/1/2 boundaries, or that fails to restart the prescaler at a phase boundary, since either one shifts the measured cycle count. It holds the line low through a high phase and confirms the clock neither advances nor starts a low phase. It then counts the exact delay after release, which exposes a design that counts during the stretch. It also changes the settings while the block is enabled, and confirms the period does not change. It drops `run` in the middle of a low phase and expects exactly one trailing high phase. It programs a high count of zero and expects no clock at all.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Per-phase overhead in module ticks, selected by the prescale setting.
  function automatic logic [2:0] phase_overhead(input logic [31:0] pre,
                                                input logic        fixed6);
    if (fixed6)          return 3'd6;
    else if (pre == 32'd0) return 3'd7;
    else if (pre == 32'd1) return 3'd6;
    else                 return 3'd5;
  endfunction

  // Total phase length in module ticks.
  function automatic logic [31:0] phase_ticks(input logic [31:0] count,
                                              input logic [2:0]  ovh);
    return count + {29'd0, ovh};
  endfunction

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b1;
        else        q <= d_in;
      end
      assign q_out = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], d_in};
      end
      assign q_out = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;

  assign tick = adv && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             done
);

  logic [LEN_W-1:0] pc_q;
  logic [LEN_W-1:0] last_idx;

  assign last_idx = len - 1'b1;
  assign done     = tick && (pc_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (clr)   pc_q <= '0;
    else if (tick)  pc_q <= done ? '0 : pc_q + 1'b1;
  end

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CNT_W       = 16,
  parameter bit FIXED_OVH   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             run,
  input  logic [CNT_W-1:0] psc_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [CNT_W-1:0] hi_in,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             phase_end,
  output logic             stretch_wait
);

  import scl_div_pkg::*;

  localparam int LEN_W = CNT_W + 1;

  // Captured settings: loaded only while the module is disabled.
  logic [CNT_W-1:0] psc_q, lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (!mod_en) begin
      psc_q <= psc_in;
      lo_q  <= lo_in;
      hi_q  <= hi_in;
    end
  end

  // Named internal events.
  logic       scl_s;
  logic       tick;
  logic       done;
  logic       clr;
  logic       adv;
  logic       start_ok;
  logic [2:0] ovh;
  logic [LEN_W-1:0] lo_len, hi_len, cur_len;

  assign ovh    = phase_overhead(32'(psc_q), FIXED_OVH);
  assign lo_len = LEN_W'(phase_ticks(32'(lo_q), ovh));
  assign hi_len = LEN_W'(phase_ticks(32'(hi_q), ovh));

  scl_phase_e state_q, state_d;

  assign start_ok = mod_en && run && (hi_q != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (start_ok) state_d = PH_LOW;
      PH_LOW:  if (done)     state_d = PH_HIGH;
      PH_HIGH: if (done)     state_d = run ? PH_LOW : PH_IDLE;
      default:               state_d = PH_IDLE;
    endcase
    if (!mod_en) state_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign clr     = (state_d != state_q);
  assign adv     = (state_q == PH_LOW) || ((state_q == PH_HIGH) && scl_s);
  assign cur_len = (state_q == PH_LOW) ? lo_len : hi_len;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (scl_in),
    .q_out (scl_s)
  );

  scl_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (adv),
    .div   (psc_q),
    .tick  (tick)
  );

  scl_phase_counter #(.LEN_W(LEN_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .tick  (tick),
    .len   (cur_len),
    .done  (done)
  );

  assign scl_o        = (state_q != PH_LOW);
  assign phase_end    = done && mod_en;
  assign stretch_wait = (state_q == PH_HIGH) && !scl_s;

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_en,
  input logic             scl_o,
  input logic             phase_end,
  input logic             stretch_wait,
  input logic [CNT_W-1:0] cfg_psc,
  input logic [CNT_W-1:0] cfg_lo,
  input logic [CNT_W-1:0] cfg_hi
);

  // R7
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> scl_o);

  // R6
  no_clock_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hi == '0) |-> scl_o);

  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_wait |-> !phase_end);

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> !phase_end);

  // R2
  low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && !scl_o) |=> scl_o);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && $past(mod_en)) |-> ($stable(cfg_psc) && $stable(cfg_lo) && $stable(cfg_hi)));

endmodule

bind scl_clkgen scl_clkgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mod_en       (mod_en),
  .scl_o        (scl_o),
  .phase_end    (phase_end),
  .stretch_wait (stretch_wait),
  .cfg_psc      (psc_q),
  .cfg_lo       (lo_q),
  .cfg_hi       (hi_q)
);

// File: tb/tb_scl_clkgen.sv
module tb_scl_clkgen;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0;
  logic run = 1'b0;
  logic stretch = 1'b0;
  logic [W-1:0] psc = '0, lo = '0, hi = '0;
  logic scl_o, phase_end, stretch_wait;
  logic scl_fx, pe_fx, sw_fx;
  logic scl_line;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = scl_o & ~stretch;

  scl_clkgen #(.CNT_W(W), .FIXED_OVH(1'b0), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .run(run),
    .psc_in(psc), .lo_in(lo), .hi_in(hi), .scl_in(scl_line),
    .scl_o(scl_o), .phase_end(phase_end), .stretch_wait(stretch_wait)
  );

  scl_clkgen #(.CNT_W(W), .FIXED_OVH(1'b1), .SYNC_STAGES(SYNC)) dut_fx (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .run(run),
    .psc_in(psc), .lo_in(lo), .hi_in(hi), .scl_in(scl_fx),
    .scl_o(scl_fx), .phase_end(pe_fx), .stretch_wait(sw_fx)
  );

  // psc, lo, hi, expected low cycles, expected high cycles (d = 7/6/5)
  localparam int unsigned VEC [5][5] = '{
    '{0, 3, 2, 10, 11},
    '{1, 4, 3, 20, 20},
    '{3, 2, 1, 28, 26},
    '{0, 0, 1,  7, 10},
    '{2, 1, 4, 18, 29}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic sample(input bit fx);
    return fx ? scl_fx : scl_o;
  endfunction

  task automatic configure(input int p, input int l, input int h);
    @(negedge clk);
    mod_en = 1'b0;
    run    = 1'b0;
    psc = W'(p); lo = W'(l); hi = W'(h);
    repeat (3) @(negedge clk);
    run    = 1'b1;
    mod_en = 1'b1;
  endtask

  task automatic wait_level(input bit fx, input logic lvl);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (sample(fx) == lvl) break;
    end
  endtask

  // Measures one full low phase and the high phase after it.
  task automatic measure(input bit fx, output int lo_n, output int hi_n, output int pe_n);
    wait_level(fx, 1'b1);
    wait_level(fx, 1'b0);
    lo_n = 0; pe_n = 0;
    while (sample(fx) == 1'b0 && lo_n < 5000) begin
      lo_n++;
      if (fx ? pe_fx : phase_end) pe_n++;
      @(negedge clk);
    end
    hi_n = 0;
    while (sample(fx) == 1'b1 && hi_n < 5000) begin
      hi_n++;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int ln, hn, pn, cnt;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 scl in reset", int'(scl_o), 1);
    check("R1 phase_end in reset", int'(phase_end), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 scl after reset", int'(scl_o), 1);
    check("R1 stretch_wait after reset", int'(stretch_wait), 0);

    // R2 R3 R4 R11: table of prescale/count settings
    for (int v = 0; v < 5; v++) begin
      configure(int'(VEC[v][0]), int'(VEC[v][1]), int'(VEC[v][2]));
      measure(1'b0, ln, hn, pn);
      check($sformatf("R2 R4 low len vec%0d", v), ln, int'(VEC[v][3]));
      check($sformatf("R3 R4 high len vec%0d", v), hn, int'(VEC[v][4]));
      check($sformatf("R11 pulses per low vec%0d", v), pn, 1);
    end

    // R5: fixed overhead instance, d = 6
    configure(0, 3, 2);
    measure(1'b1, ln, hn, pn);
    check("R5 low len psc0", ln, 9);
    check("R5 high len psc0", hn, 10);
    configure(3, 3, 2);
    measure(1'b1, ln, hn, pn);
    check("R5 low len psc3", ln, 36);
    check("R5 high len psc3", hn, 34);

    // R8: settings changed while enabled are ignored
    configure(0, 3, 2);
    wait_level(1'b0, 1'b0);
    lo = W'(20); hi = W'(9); psc = W'(4);
    measure(1'b0, ln, hn, pn);
    check("R8 low len unchanged", ln, 10);
    check("R8 high len unchanged", hn, 11);

    // R9: clock stretching
    configure(0, 3, 2);
    wait_level(1'b0, 1'b0);
    stretch = 1'b1;
    wait_level(1'b0, 1'b1);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!scl_o) cnt++;
    end
    check("R9 no low while stretched", cnt, 0);
    check("R9 stretch_wait raised", int'(stretch_wait), 1);
    stretch = 1'b0;
    cnt = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cnt++;
      if (!scl_o) break;
    end
    check("R9 delay after release", cnt, SYNC + 9);

    // R7: disable mid low phase
    configure(1, 4, 3);
    wait_level(1'b0, 1'b0);
    mod_en = 1'b0;
    @(negedge clk);
    check("R7 scl released after disable", int'(scl_o), 1);

    // R10: run dropped during low phase
    configure(0, 3, 2);
    wait_level(1'b0, 1'b0);
    run = 1'b0;
    wait_level(1'b0, 1'b1);
    cnt = 0; pn = 0;
    for (int i = 0; i < 200; i++) begin
      if (!scl_o) cnt++;
      if (phase_end) pn++;
      @(negedge clk);
    end
    check("R10 no low after run drop", cnt, 0);
    check("R10 single trailing high end", pn, 1);

    // R6: zero high count gives no clock
    configure(0, 3, 0);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!scl_o) cnt++;
    end
    check("R6 no clock with hi zero", cnt, 0);

    summary();
    $finish;
  end

endmodule